// File: doc/BRIEF.md
# Seven-Level Phase-Shifted Carrier Gate Generator

This block produces the gate commands for one phase leg of a hybrid multilevel converter. The leg is a three-level actively clamped stage with a chain of two-level flying-capacitor cells. With `CELLS` cells the leg reaches `2*CELLS+3` output levels, and the default of two cells gives seven levels. A signed sinusoidal reference sample and a modulation index come in. The block latches the reference once per carrier cycle and folds it into a single carrier band for each half wave. It then compares that band against `CELLS+1` digital triangles, shifted evenly over a full carrier period.

The clamp switches (the "tie" pairs) change state only when the sampled reference changes sign. They connect the cell chain to the upper DC-link capacitor for a positive reference and to the lower one for a negative reference. Each complementary pair goes through a dead-time stage. The block also reports the commanded output level in units of the innermost cell voltage. Either a leading or a lagging carrier order can be chosen. A reset, or dropping the enable, opens every switch.

Top module: `psc_ml_pwm`

## Requirements
- R1: The number of carriers K is `CELLS+1` and `level` stays within -K..+K. With the default of two cells, K is 3 and `level` runs from -3 to +3.
- R2: The reference is latched only when carrier 0 reaches its peak. Let m = floor(|ref_in|·mod_idx·period / 2^(REF_W-1+IDX_W)), limited to `period`. The threshold is then t = m for ref_in ≥ 0 and t = period − m for ref_in < 0.
- R3: Each triangle counts 0,1,…,period,period−1,…,1 and repeats, so one cycle is 2·period clocks. The command of carrier k is on while its count is below t. Over any 2·period consecutive clocks with t held, each carrier is therefore commanded on for 2t−1 clocks (for 1 ≤ t ≤ period), or 0 clocks when t = 0.
- R4: `level` = K·(h−1) + (number of carriers commanded on). Here h is 1 in the positive half and 0 in the negative half.
- R5: In the positive half, outer_g[0] and outer_g[2] are on and outer_g[1] and outer_g[3] are off, so `outer_g` = 4'b0101. The negative half gives 4'b1010.
- R6: Carrier k starts at cycle position 2·period·k/K in leading order, or 2·period·((K−k) mod K)/K in lagging order. Carrier 0 drives inner_g[0], and carrier j+1 drives cell_g[2j]. For a small positive threshold right after reset, the first turn-on order is cell_g[0], inner_g[0], cell_g[2] when leading, and cell_g[2], inner_g[0], cell_g[0] when lagging.
- R7: Pairs are (outer_g[0],outer_g[1]), (outer_g[2],outer_g[3]), (inner_g[0],inner_g[1]) and (cell_g[2j],cell_g[2j+1]). Both switches of a pair are never on together. When a pair's command changes, the conducting switch opens at once and the other closes after `dead_cyc`+1 clocks with both open.
- R8: When `rst` or a low `en` is seen at a clock edge, every gate output and `level` are 0 after that edge. The triangles restart from their start positions.
- R9: A `mod_idx` of 0 with a positive reference holds `level` at 0. A `mod_idx` of 0 with a negative reference gives a `level` sum of −K over one carrier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low opens all switches |
| lag_sel | input | 1 | 0 leading carrier order, 1 lagging |
| period | input | CNT_W | Triangle half-period in clocks |
| dead_cyc | input | DT_W | Dead time in clocks |
| ref_in | input | REF_W | Signed reference sample, full scale 2^(REF_W-1) |
| mod_idx | input | IDX_W | Modulation index, full scale 2^IDX_W |
| outer_g | output | 4 | Clamp switch gates (two tie pairs) |
| inner_g | output | 2 | Inner complementary pair gates |
| cell_g | output | 2*CELLS | Cell pair gates, even bit upper switch |
| level | output | $clog2(CELLS+2)+1 | Signed commanded output level |

## Verification
The hardest condition to reach is the dead-time gap of the clamp pairs. It occurs only when the reference changes sign and then only at the next carrier-0 peak, so the bench reverses the reference sign and counts the clocks in which both tie switches are open over a window of several carrier cycles. The carrier phase order can only be seen from turn-on times, so the bench resets the block with a small positive reference under each arrangement and compares the cycles at which three gates first switch on. The modulation itself is checked through the level sum over one carrier cycle, because that sum does not depend on pipeline alignment.

// File: rtl/psc_ml_pwm_pkg.sv
package psc_ml_pwm_pkg;

  typedef enum logic {ORDER_LEAD = 1'b0, ORDER_LAG = 1'b1} order_e;

  // Start position inside one 2*per carrier cycle for carrier idx of k
  function automatic int unsigned start_pos(input int unsigned per,
                                            input int unsigned idx,
                                            input int unsigned k,
                                            input logic        lag);
    int unsigned m;
    m = lag ? ((k - idx) % k) : idx;
    return (2 * per * m) / k;
  endfunction

endpackage

// File: rtl/psc_ml_pwm_carrier.sv
module psc_ml_pwm_carrier #(
  parameter int CNT_W = 16,
  parameter int ID    = 0,
  parameter int CARR  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lag,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             peak
);
  import psc_ml_pwm_pkg::*;

  logic             up;
  logic [CNT_W:0]   pos0;
  logic [CNT_W:0]   per_x;
  logic [CNT_W:0]   full;
  logic [CNT_W-1:0] load_cnt;
  logic             load_up;

  always_comb begin
    per_x    = {1'b0, period};
    full     = {period, 1'b0};
    pos0     = (CNT_W+1)'(start_pos(32'(period), ID, CARR, lag));
    load_up  = (pos0 < per_x);
    if (load_up) load_cnt = pos0[CNT_W-1:0];
    else         load_cnt = CNT_W'(full - pos0);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= load_cnt;
      up  <= load_up;
    end else if (up) begin
      if (cnt >= period) begin
        up  <= 1'b0;
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        up  <= 1'b1;
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign peak = en && (cnt >= period);

endmodule

// File: rtl/psc_ml_pwm_fold.sv
module psc_ml_pwm_fold #(
  parameter int REF_W = 12,
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [IDX_W-1:0]        mod_idx,
  input  logic [CNT_W-1:0]        period,
  output logic                    pos,
  output logic [CNT_W-1:0]        thr
);
  localparam int PW = REF_W + IDX_W + CNT_W;
  localparam int SH = REF_W - 1 + IDX_W;

  logic [REF_W-1:0] mag;
  logic [PW-1:0]    prod;
  logic [PW-1:0]    scaled;
  logic [CNT_W-1:0] depth;
  logic             sgn_pos;

  always_comb begin
    sgn_pos = !ref_in[REF_W-1];
    mag     = sgn_pos ? ref_in : REF_W'(-ref_in);
    prod    = PW'(mag) * PW'(mod_idx) * PW'(period);
    scaled  = prod >> SH;
    if (scaled > PW'(period)) depth = period;
    else                      depth = scaled[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= 1'b1;
      thr <= '0;
    end else if (take) begin
      pos <= sgn_pos;
      thr <= sgn_pos ? depth : period - depth;
    end
  end

endmodule

// File: rtl/psc_ml_pwm_deadband.sv
module psc_ml_pwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            want,
  input  logic [DT_W-1:0] dead,
  output logic            hi,
  output logic            lo
);
  logic            cur;
  logic [DT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cur      <= 1'b0;
      wait_cnt <= dead;
      hi       <= 1'b0;
      lo       <= 1'b0;
    end else if (want != cur) begin
      cur      <= want;
      wait_cnt <= dead;
      hi       <= 1'b0;
      lo       <= 1'b0;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
      hi       <= 1'b0;
      lo       <= 1'b0;
    end else begin
      hi <= cur;
      lo <= !cur;
    end
  end

endmodule

// File: rtl/psc_ml_pwm.sv
module psc_ml_pwm #(
  parameter int CELLS = 2,
  parameter int REF_W = 12,
  parameter int IDX_W = 8,
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 en,
  input  logic                                 lag_sel,
  input  logic [CNT_W-1:0]                     period,
  input  logic [DT_W-1:0]                      dead_cyc,
  input  logic signed [REF_W-1:0]              ref_in,
  input  logic [IDX_W-1:0]                     mod_idx,
  output logic [3:0]                           outer_g,
  output logic [1:0]                           inner_g,
  output logic [2*CELLS-1:0]                   cell_g,
  output logic signed [$clog2(CELLS+2):0]      level
);
  localparam int CARR   = CELLS + 1;
  localparam int LEVELS = 2 * CELLS + 3;
  localparam int LVL_W  = $clog2(CELLS + 2) + 1;
  localparam logic signed [LVL_W-1:0] K_S = LVL_W'(CARR);

  logic [CNT_W-1:0]      cnt [CARR];
  logic [CARR-1:0]       peak;
  logic                  pos;
  logic [CNT_W-1:0]      thr;
  logic [CARR-1:0]       cmd_q;
  logic                  pos_q;
  logic signed [LVL_W-1:0] ones;
  logic signed [LVL_W-1:0] lvl_d;

  // Triangular carriers, evenly shifted over one carrier cycle
  for (genvar k = 0; k < CARR; k++) begin : g_carr
    psc_ml_pwm_carrier #(.CNT_W(CNT_W), .ID(k), .CARR(CARR)) u_carr (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .lag    (lag_sel),
      .period (period),
      .cnt    (cnt[k]),
      .peak   (peak[k])
    );
  end

  // Reference fold, latched at the carrier-0 peak
  psc_ml_pwm_fold #(.REF_W(REF_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fold (
    .clk     (clk),
    .rst     (rst),
    .take    (peak[0]),
    .ref_in  (ref_in),
    .mod_idx (mod_idx),
    .period  (period),
    .pos     (pos),
    .thr     (thr)
  );

  // Comparators
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cmd_q <= '0;
      pos_q <= 1'b1;
    end else begin
      for (int k = 0; k < CARR; k++) cmd_q[k] <= (thr > cnt[k]);
      pos_q <= pos;
    end
  end

  // Commanded level
  always_comb begin
    ones = '0;
    for (int k = 0; k < CARR; k++) ones = ones + LVL_W'({1'b0, cmd_q[k]});
    lvl_d = pos_q ? ones : ones - K_S;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) level <= '0;
    else            level <= lvl_d;
  end

  // Clamp tie pairs: both follow the half-wave sign
  for (genvar p = 0; p < 2; p++) begin : g_tie
    psc_ml_pwm_deadband #(.DT_W(DT_W)) u_db (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .want (pos_q),
      .dead (dead_cyc),
      .hi   (outer_g[2*p]),
      .lo   (outer_g[2*p+1])
    );
  end

  psc_ml_pwm_deadband #(.DT_W(DT_W)) u_db_inner (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .want (cmd_q[0]),
    .dead (dead_cyc),
    .hi   (inner_g[0]),
    .lo   (inner_g[1])
  );

  for (genvar j = 0; j < CELLS; j++) begin : g_cell
    psc_ml_pwm_deadband #(.DT_W(DT_W)) u_db (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .want (cmd_q[j+1]),
      .dead (dead_cyc),
      .hi   (cell_g[2*j]),
      .lo   (cell_g[2*j+1])
    );
  end

  initial begin
    if (LEVELS != 2 * CARR + 1) $error("level count mismatch");
  end

endmodule

// File: rtl/psc_ml_pwm_chk.sv
module psc_ml_pwm_chk #(
  parameter int CELLS = 2,
  parameter int REF_W = 12,
  parameter int IDX_W = 8,
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            en,
  input logic [3:0]                      outer_g,
  input logic [1:0]                      inner_g,
  input logic [2*CELLS-1:0]              cell_g,
  input logic signed [$clog2(CELLS+2):0] level
);
  localparam int NP   = CELLS + 3;
  localparam int LV_W = $clog2(CELLS + 2) + 1;
  localparam logic signed [LV_W-1:0] KMAX = LV_W'(CELLS + 1);

  logic [NP-1:0] hi_v;
  logic [NP-1:0] lo_v;

  always_comb begin
    hi_v[0] = outer_g[0];
    lo_v[0] = outer_g[1];
    hi_v[1] = outer_g[2];
    lo_v[1] = outer_g[3];
    hi_v[2] = inner_g[0];
    lo_v[2] = inner_g[1];
    for (int j = 0; j < CELLS; j++) begin
      hi_v[3+j] = cell_g[2*j];
      lo_v[3+j] = cell_g[2*j+1];
    end
  end

  p_pair_excl_r7: assert property (@(posedge clk) disable iff (rst)
    ((hi_v & lo_v) == '0));

  p_gap_before_on_r7: assert property (@(posedge clk) disable iff (rst)
    (((hi_v & ~$past(hi_v) & $past(lo_v)) | (lo_v & ~$past(lo_v) & $past(hi_v))) == '0));

  p_idle_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (outer_g == '0 && inner_g == '0 && cell_g == '0 && level == '0));

  p_level_range_r1: assert property (@(posedge clk) disable iff (rst)
    (level >= -KMAX && level <= KMAX));

endmodule

bind psc_ml_pwm psc_ml_pwm_chk #(
  .CELLS(CELLS), .REF_W(REF_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DT_W(DT_W)
) u_chk (.*);

// File: tb/psc_ml_pwm_bench.sv
module psc_ml_pwm_bench;
  localparam int CELLS = 2;
  localparam int REF_W = 12;
  localparam int IDX_W = 8;
  localparam int CNT_W = 16;
  localparam int DT_W  = 8;
  localparam int K     = CELLS + 1;
  localparam int PER   = 24;
  localparam int DEAD  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic lag_sel = 1'b0;
  logic [CNT_W-1:0] period = CNT_W'(PER);
  logic [DT_W-1:0]  dead_cyc = DT_W'(DEAD);
  logic signed [REF_W-1:0] ref_in = '0;
  logic [IDX_W-1:0] mod_idx = '0;
  logic [3:0] outer_g;
  logic [1:0] inner_g;
  logic [2*CELLS-1:0] cell_g;
  logic signed [$clog2(CELLS+2):0] level;

  int nvec = 0;
  int nfail = 0;
  int overlap = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psc_ml_pwm #(.CELLS(CELLS), .REF_W(REF_W), .IDX_W(IDX_W),
               .CNT_W(CNT_W), .DT_W(DT_W)) u_psc_ml_pwm (
    .clk(clk), .rst(rst), .en(en), .lag_sel(lag_sel), .period(period),
    .dead_cyc(dead_cyc), .ref_in(ref_in), .mod_idx(mod_idx),
    .outer_g(outer_g), .inner_g(inner_g), .cell_g(cell_g), .level(level)
  );

  // R7 pair exclusivity monitor
  always @(negedge clk) begin
    if (!rst) begin
      if ((outer_g[0] && outer_g[1]) || (outer_g[2] && outer_g[3]) ||
          (inner_g[0] && inner_g[1]) || (cell_g[0] && cell_g[1]) ||
          (cell_g[2] && cell_g[3]))
        overlap++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Expected threshold per R2
  function automatic int exp_thr(input int r, input int idx);
    longint mag, m;
    mag = (r < 0) ? -r : r;
    m = (mag * idx * PER) >>> (REF_W - 1 + IDX_W);
    if (m > PER) m = PER;
    return (r < 0) ? PER - int'(m) : int'(m);
  endfunction

  // Expected level sum over one carrier cycle per R3/R4
  function automatic int exp_sum(input int r, input int idx);
    int t, on;
    t = exp_thr(r, idx);
    on = (t == 0) ? 0 : 2 * t - 1;
    return K * on - ((r < 0) ? K * 2 * PER : 0);
  endfunction

  task automatic level_sum(output int s, output int mx, output int mn);
    s = 0; mx = -100; mn = 100;
    for (int i = 0; i < 2 * PER; i++) begin
      @(negedge clk);
      s += int'(level);
      if (int'(level) > mx) mx = int'(level);
      if (int'(level) < mn) mn = int'(level);
    end
  endtask

  task automatic do_reset(input bit lag);
    @(negedge clk);
    rst = 1'b1; en = 1'b0; lag_sel = lag;
    wait_cyc(3);
    rst = 1'b0; en = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    wait_cyc(2);
    check(outer_g == 4'b0 && inner_g == 2'b0 && cell_g == '0, "R8 reset gates",
          int'({outer_g, inner_g, cell_g}), 0);
    check(level == '0, "R8 reset level", int'(level), 0);
    rst = 1'b0;
  endtask

  task automatic t_modulate(input int r, input int idx, input string tag);
    int s, mx, mn;
    ref_in = REF_W'(r); mod_idx = IDX_W'(idx);
    wait_cyc(6 * PER);
    level_sum(s, mx, mn);
    check(s == exp_sum(r, idx), {tag, " R3 R4 level sum"}, s, exp_sum(r, idx));
    check(mx <= K && mn >= -K, {tag, " R1 level range"}, mx, K);
    if (r >= 0) check(outer_g == 4'b0101, {tag, " R5 positive tie"}, int'(outer_g), 5);
    else        check(outer_g == 4'b1010, {tag, " R5 negative tie"}, int'(outer_g), 10);
  endtask

  task automatic t_full_swing();
    int s, mx, mn;
    ref_in = 12'sd2047; mod_idx = 8'd255;
    wait_cyc(6 * PER);
    level_sum(s, mx, mn);
    check(s == exp_sum(2047, 255), "R2 full scale sum", s, exp_sum(2047, 255));
    check(mx == K, "R1 peak level", mx, K);
  endtask

  task automatic t_zero_index();
    int s, mx, mn;
    ref_in = 12'sd1500; mod_idx = '0;
    wait_cyc(6 * PER);
    level_sum(s, mx, mn);
    check(s == 0 && mx == 0 && mn == 0, "R9 zero index positive", s, 0);
    ref_in = -12'sd1500;
    wait_cyc(6 * PER);
    level_sum(s, mx, mn);
    check(s == -K, "R9 zero index negative", s, -K);
  endtask

  task automatic t_dead_time();
    int gap0, gap1;
    ref_in = 12'sd1024; mod_idx = 8'd128;
    wait_cyc(6 * PER);
    check(outer_g == 4'b0101, "R5 tie before flip", int'(outer_g), 5);
    gap0 = 0; gap1 = 0;
    ref_in = -12'sd1024;
    for (int i = 0; i < 6 * PER; i++) begin
      @(negedge clk);
      if (!outer_g[0] && !outer_g[1]) gap0++;
      if (!outer_g[2] && !outer_g[3]) gap1++;
    end
    check(gap0 == DEAD + 1, "R7 tie pair 0 gap", gap0, DEAD + 1);
    check(gap1 == DEAD + 1, "R7 tie pair 1 gap", gap1, DEAD + 1);
    check(outer_g == 4'b1010, "R5 tie after flip", int'(outer_g), 10);
  endtask

  task automatic t_disable();
    ref_in = 12'sd1024; mod_idx = 8'd128;
    wait_cyc(6 * PER);
    en = 1'b0;
    wait_cyc(1);
    check(outer_g == 4'b0 && inner_g == 2'b0 && cell_g == '0 && level == '0,
          "R8 enable low", int'({outer_g, inner_g, cell_g}), 0);
    wait_cyc(4);
    check(outer_g == 4'b0 && inner_g == 2'b0 && cell_g == '0, "R8 held off",
          int'({outer_g, inner_g, cell_g}), 0);
    en = 1'b1;
  endtask

  task automatic t_order(input bit lag);
    int fa, fb, fc, cyc;
    ref_in = 12'sd1024; mod_idx = 8'd128;
    do_reset(lag);
    fa = -1; fb = -1; fc = -1;
    for (cyc = 0; cyc < 5 * PER; cyc++) begin
      @(negedge clk);
      if (cell_g[0] && fa < 0) fa = cyc;
      if (inner_g[0] && fb < 0) fb = cyc;
      if (cell_g[2] && fc < 0) fc = cyc;
    end
    if (!lag)
      check(fa >= 0 && fa < fb && fb < fc, "R6 leading order", fa, fb);
    else
      check(fc >= 0 && fc < fb && fb < fa, "R6 lagging order", fc, fb);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    do_reset(1'b0);
    t_modulate(1024, 128, "mid positive");
    t_modulate(-1536, 200, "negative");
    t_full_swing();
    t_zero_index();
    t_dead_time();
    t_disable();
    t_order(1'b0);
    t_order(1'b1);
    check(overlap == 0, "R7 pair overlap", overlap, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule